// File: doc/BRIEF.md
# Soft-Ramping Stereo Digital Volume

This block scales a pair of 24-bit signed audio samples by a per-channel gain chosen with an 8-bit attenuation code. Code 0 is the loudest setting, at about +31 dB. Each step up in the code lowers the gain by one half-decibel notch. Code 62 is exact unity. Code 254 is near -96 dB, and code 255 silences the channel. The gain is built from a 12-entry mantissa table and an arithmetic right shift. Twelve notches make exactly one octave, so one notch is about 0.502 dB. The scaled result is clamped to the 24-bit signed range and registered.

The gain that is actually applied does not jump to a new code. Each channel keeps an applied level. That level walks one code at a time toward an effective target, dwelling four frame strobes on each code, so volume changes produce no clicks.

The effective target is chosen as follows:
- While soft mute is requested, the target is the silence code.
- Otherwise the right channel's target is set either by its own code or, when the channels are linked, by the left code.

Releasing soft mute partway simply turns the walk around at the current level. The integrating register bank is expected to power up with soft mute requested, with the channels linked and with both codes at 62. A synchronous reset loads each applied level straight to its target.

Top module: `stereo_soft_vol`

## Requirements
- R1: At applied level L (0 to 254) the output is the input times 2^(-(L-62)/12). L = 62 passes the input unchanged, and L = 74 gives exactly half (rounded toward minus infinity).
- R2: At applied level 255 both the output and the channel are exactly zero.
- R3: Results beyond the 24-bit signed range clamp to 8388607 or to -8388608 and never wrap.
- R4: The applied level changes only on a clock where frame_strb is high. It changes by exactly one code toward the effective target, and only on every fourth such strobe while it differs from the target. While the level equals the target, the strobe count is cleared.
- R5: A walk from code 62 to code 254 takes 768 strobes, and a walk from code 0 to code 254 takes 1016 strobes.
- R6: With link_lr = 1 the right channel targets code_l and code_r has no effect. With link_lr = 0 the right channel targets code_r.
- R7: With mute_req = 1 the target is 255 on both channels, and from code 62 silence is reached after 772 strobes.
- R8: If mute_req drops before silence is reached, the level walks back from where it stands to the channel code at the same four-strobe rate.
- R9: While rst is high on a clock edge, each applied level is loaded directly with its effective target and the outputs are cleared to zero.
- R10: Each output is registered: the output after a clock edge reflects the input sample and the applied level present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strb | input | 1 | One-clock pulse per audio frame; paces the level walk |
| link_lr | input | 1 | 1: code_l sets both channels |
| mute_req | input | 1 | Soft-mute request: walk to silence |
| code_l | input | 8 | Left (or shared) attenuation code |
| code_r | input | 8 | Right attenuation code |
| smp_l_in | input | 24 | Left sample, two's complement |
| smp_r_in | input | 24 | Right sample, two's complement |
| smp_l_out | output | 24 | Scaled left sample |
| smp_r_out | output | 24 | Scaled right sample |

## Verification
A wrong applied level shows one clock later as an output that is wrong by at least one notch, about 6 %. The bench's cycle model therefore compares the outputs on every clock with a tolerance far below that. A wrong dwell counter does not alter the output until a level boundary, so the ramp lengths are measured one strobe at a time. This catches any off-by-one in the 768, 772 and 1016 figures, and in the reversal length, on the exact strobe where it occurs.

// File: rtl/svol_pkg.sv
package svol_pkg;

    localparam int MANT_FRAC     = 15;
    localparam int MANT_W        = MANT_FRAC + 2;
    localparam int STEPS_PER_OCT = 12;
    localparam int GAIN_SH_W     = 6;

    typedef enum logic [1:0] {
        LVL_HOLD = 2'd0,
        LVL_INC  = 2'd1,
        LVL_DEC  = 2'd2
    } lvl_dir_e;

    typedef struct packed {
        logic                 mute;
        logic [MANT_W-1:0]    mant;
        logic [GAIN_SH_W-1:0] shift;
    } gain_t;

    // 2^(-r/12) in unsigned Q1.15
    function automatic logic [MANT_W-1:0] mant_lut(input logic [3:0] r);
        logic [MANT_W-1:0] m;
        unique case (r)
            4'd0:    m = 17'd32768;
            4'd1:    m = 17'd30929;
            4'd2:    m = 17'd29193;
            4'd3:    m = 17'd27554;
            4'd4:    m = 17'd26008;
            4'd5:    m = 17'd24548;
            4'd6:    m = 17'd23170;
            4'd7:    m = 17'd21870;
            4'd8:    m = 17'd20643;
            4'd9:    m = 17'd19484;
            4'd10:   m = 17'd18390;
            4'd11:   m = 17'd17358;
            default: m = 17'd32768;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/svol_ramp.sv
module svol_ramp
    import svol_pkg::*;
#(
    parameter int CODE_W          = 8,
    parameter int FRAMES_PER_STEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_strb,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] lvl
);

    localparam int CNT_W = (FRAMES_PER_STEP > 1) ? $clog2(FRAMES_PER_STEP) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAMES_PER_STEP - 1);

    logic [CNT_W-1:0] dwell_cnt;
    lvl_dir_e         dir;

    always_comb begin
        if (lvl < target)      dir = LVL_INC;
        else if (lvl > target) dir = LVL_DEC;
        else                   dir = LVL_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl       <= target;
            dwell_cnt <= '0;
        end else if (frame_strb) begin
            if (dir == LVL_HOLD) begin
                dwell_cnt <= '0;
            end else if (dwell_cnt == CNT_LAST) begin
                dwell_cnt <= '0;
                lvl       <= (dir == LVL_INC) ? lvl + CODE_W'(1) : lvl - CODE_W'(1);
            end else begin
                dwell_cnt <= dwell_cnt + CNT_W'(1);
            end
        end
    end

    // R4: no movement without a strobe
    assert_hold_no_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !frame_strb |=> $stable(lvl));

    // R4: moves are single codes
    assert_unit_step_R4: assert property (@(posedge clk) disable iff (rst)
        frame_strb |=> (lvl == $past(lvl)) || (lvl == $past(lvl) + CODE_W'(1))
                       || (lvl == $past(lvl) - CODE_W'(1)));

    // R5: a code is left only after its full dwell
    assert_dwell_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_strb && dwell_cnt != CNT_LAST) |=> $stable(lvl));

    // R8: never walks away from a lower target
    assert_toward_lower_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_strb && lvl > target) |=> lvl <= $past(lvl));

endmodule

// File: rtl/svol_gain.sv
module svol_gain
    import svol_pkg::*;
#(
    parameter int SMP_W      = 24,
    parameter int CODE_W     = 8,
    parameter int UNITY_CODE = 62
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CODE_W-1:0]       lvl,
    input  logic signed [SMP_W-1:0] smp_in,
    output logic signed [SMP_W-1:0] smp_out
);

    localparam int OCT_K    = (UNITY_CODE + STEPS_PER_OCT - 1) / STEPS_PER_OCT;
    localparam int BIAS     = OCT_K * STEPS_PER_OCT - UNITY_CODE;
    localparam int PROD_W   = SMP_W + MANT_W;
    localparam int MUTE_LVL = (2 ** CODE_W) - 1;
    localparam logic signed [PROD_W-1:0] LIM_HI = PROD_W'((2 ** (SMP_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] LIM_LO = -LIM_HI - PROD_W'(1);
    localparam logic signed [SMP_W-1:0]  OUT_HI = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic signed [SMP_W-1:0]  OUT_LO = {1'b1, {(SMP_W-1){1'b0}}};

    gain_t                    g;
    int                       pos;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [SMP_W-1:0]  sat_v;

    always_comb begin
        pos     = int'(lvl) + BIAS;
        g.mute  = (lvl == CODE_W'(MUTE_LVL));
        g.mant  = mant_lut(4'(pos % STEPS_PER_OCT));
        g.shift = GAIN_SH_W'(pos / STEPS_PER_OCT + MANT_FRAC - OCT_K);
    end

    assign prod   = smp_in * $signed(g.mant);
    assign scaled = prod >>> g.shift;

    always_comb begin
        if (g.mute)               sat_v = '0;
        else if (scaled > LIM_HI) sat_v = OUT_HI;
        else if (scaled < LIM_LO) sat_v = OUT_LO;
        else                      sat_v = scaled[SMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) smp_out <= '0;
        else     smp_out <= sat_v;
    end

    assert_unity_pass_R1: assert property (@(posedge clk) disable iff (rst)
        (lvl == CODE_W'(UNITY_CODE)) |=> smp_out == $past(smp_in));

    assert_silence_R2: assert property (@(posedge clk) disable iff (rst)
        (lvl == CODE_W'(MUTE_LVL)) |=> smp_out == '0);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (lvl <= CODE_W'(UNITY_CODE) && smp_in >= 0) |=> smp_out >= $past(smp_in));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        (lvl <= CODE_W'(UNITY_CODE) && smp_in < 0) |=> smp_out <= $past(smp_in));

endmodule

// File: rtl/stereo_soft_vol.sv
module stereo_soft_vol
    import svol_pkg::*;
#(
    parameter int SMP_W           = 24,
    parameter int CODE_W          = 8,
    parameter int FRAMES_PER_STEP = 4,
    parameter int UNITY_CODE      = 62
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_strb,
    input  logic              link_lr,
    input  logic              mute_req,
    input  logic [CODE_W-1:0] code_l,
    input  logic [CODE_W-1:0] code_r,
    input  logic [SMP_W-1:0]  smp_l_in,
    input  logic [SMP_W-1:0]  smp_r_in,
    output logic [SMP_W-1:0]  smp_l_out,
    output logic [SMP_W-1:0]  smp_r_out
);

    localparam int NCH = 2;
    localparam logic [CODE_W-1:0] MUTE_LVL = {CODE_W{1'b1}};

    logic [CODE_W-1:0]       tgt_arr [NCH];
    logic [CODE_W-1:0]       lvl_arr [NCH];
    logic signed [SMP_W-1:0] in_arr  [NCH];
    logic signed [SMP_W-1:0] out_arr [NCH];

    assign in_arr[0] = smp_l_in;
    assign in_arr[1] = smp_r_in;
    assign smp_l_out = out_arr[0];
    assign smp_r_out = out_arr[1];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        always_comb begin
            if (mute_req)                tgt_arr[ch] = MUTE_LVL;
            else if (ch == 0 || link_lr) tgt_arr[ch] = code_l;
            else                         tgt_arr[ch] = code_r;
        end

        svol_ramp #(
            .CODE_W          (CODE_W),
            .FRAMES_PER_STEP (FRAMES_PER_STEP)
        ) ramp_i (
            .clk        (clk),
            .rst        (rst),
            .frame_strb (frame_strb),
            .target     (tgt_arr[ch]),
            .lvl        (lvl_arr[ch])
        );

        svol_gain #(
            .SMP_W      (SMP_W),
            .CODE_W     (CODE_W),
            .UNITY_CODE (UNITY_CODE)
        ) gain_i (
            .clk     (clk),
            .rst     (rst),
            .lvl     (lvl_arr[ch]),
            .smp_in  (in_arr[ch]),
            .smp_out (out_arr[ch])
        );

        // R7: while muting, the level only rises toward silence
        assert_mute_rises_R7: assert property (@(posedge clk) disable iff (rst)
            (mute_req && frame_strb) |=> lvl_arr[ch] >= $past(lvl_arr[ch]));
    end

    // R6: when linked and not muting, the right channel never walks away from code_l
    assert_link_follow_R6: assert property (@(posedge clk) disable iff (rst)
        (link_lr && !mute_req && frame_strb && lvl_arr[1] < code_l)
            |=> lvl_arr[1] >= $past(lvl_arr[1]));

endmodule

// File: tb/stereo_soft_vol_tb_top.sv
module stereo_soft_vol_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst = 1'b1;
    logic              frame_strb = 1'b0;
    logic              link_lr = 1'b1;
    logic              mute_req = 1'b1;
    logic [7:0]        code_l = 8'd62;
    logic [7:0]        code_r = 8'd62;
    logic signed [23:0] smp_l_in = '0;
    logic signed [23:0] smp_r_in = '0;
    logic signed [23:0] smp_l_out;
    logic signed [23:0] smp_r_out;

    stereo_soft_vol dut_i (
        .clk(clk), .rst(rst), .frame_strb(frame_strb), .link_lr(link_lr),
        .mute_req(mute_req), .code_l(code_l), .code_r(code_r),
        .smp_l_in(smp_l_in), .smp_r_in(smp_r_in),
        .smp_l_out(smp_l_out), .smp_r_out(smp_r_out)
    );

    int    tests = 0, fails = 0, clk_tests = 0, clk_fails = 0;
    bit    wd_fail = 0;
    string cur_tag = "R9";

    // behavioural reference
    int  mlvl [2];
    int  mcnt [2];
    real expv [2];
    bit  model_valid = 0;

    function automatic int tgt_of(int ch);
        if (mute_req) return 255;
        if (ch == 1 && !link_lr) return int'(code_r);
        return int'(code_l);
    endfunction

    function automatic real predict(int s, int lv);
        real v;
        if (lv == 255) return 0.0;
        v = s * (2.0 ** (-(lv - 62) / 12.0));
        if (v > 8388607.0)  v = 8388607.0;
        if (v < -8388608.0) v = -8388608.0;
        return v;
    endfunction

    function automatic bit near(int a, real e);
        real d;
        real m;
        d = a - e;
        if (d < 0) d = -d;
        m = (e < 0) ? -e : e;
        return d <= 2.0 + m / 8192.0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int ch = 0; ch < 2; ch++) begin
                mlvl[ch] = tgt_of(ch);
                mcnt[ch] = 0;
                expv[ch] = 0.0;
            end
        end else begin
            expv[0] = predict(int'(smp_l_in), mlvl[0]);
            expv[1] = predict(int'(smp_r_in), mlvl[1]);
            if (frame_strb) begin
                for (int ch = 0; ch < 2; ch++) begin
                    int t;
                    t = tgt_of(ch);
                    if (mlvl[ch] == t) mcnt[ch] = 0;
                    else if (mcnt[ch] == 3) begin
                        mcnt[ch] = 0;
                        mlvl[ch] = (mlvl[ch] < t) ? mlvl[ch] + 1 : mlvl[ch] - 1;
                    end else mcnt[ch] = mcnt[ch] + 1;
                end
            end
        end
        model_valid = 1;
    end

    always @(negedge clk) begin
        if (model_valid) begin
            for (int ch = 0; ch < 2; ch++) begin
                int act;
                act = (ch == 0) ? int'(smp_l_out) : int'(smp_r_out);
                clk_tests++;
                if (!near(act, expv[ch])) begin
                    clk_fails++;
                    $display("FAIL %s ch%0d: actual %0d expected %0.2f", cur_tag, ch, act, expv[ch]);
                end
            end
        end
    end

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests + clk_tests + int'(wd_fail),
                 fails + clk_fails + int'(wd_fail));
        $finish;
    endtask

    task automatic tick(input logic s);
        frame_strb = s;
        @(negedge clk);
        frame_strb = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(1'b0);
        tick(1'b0);
        rst = 1'b0;
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp_v);
        tests++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic chk_near(input string tag, input int act, input real e);
        tests++;
        if (!near(act, e)) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0.2f", tag, act, e);
        end
    endtask

    // strobes until the left output matches level lv_final
    task automatic ramp_count(input int lv_final, input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            tick(1'b1);
            tick(1'b0);
            if (near(int'(smp_l_out), predict(int'(smp_l_in), lv_final))) begin
                n = i;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        wd_fail = 1;
        report();
    end

    initial begin
        int n;
        @(negedge clk);
        do_reset();
        // R9 / R2: reset with mute requested lands directly on silence
        cur_tag = "R2";
        smp_l_in = 24'sd100000;
        smp_r_in = -24'sd50000;
        tick(1'b0);
        chk_eq("R2 left silent", int'(smp_l_out), 0);
        chk_eq("R2 right silent", int'(smp_r_out), 0);

        // R9: reset loads the level with no ramp
        cur_tag = "R9";
        mute_req = 1'b0;
        code_l = 8'h50;
        do_reset();
        tick(1'b0);
        chk_near("R9 direct load", int'(smp_l_out), predict(100000, 8'h50));

        // R1: unity and -6 dB points
        cur_tag = "R1";
        code_l = 8'd62;
        do_reset();
        smp_l_in = 24'sd123457;
        smp_r_in = -24'sd777;
        tick(1'b0);
        chk_eq("R1 unity left", int'(smp_l_out), 123457);
        chk_eq("R1 unity right", int'(smp_r_out), -777);

        // R10: one-register latency
        cur_tag = "R10";
        smp_l_in = 24'sd5;
        tick(1'b0);
        chk_eq("R10 latency a", int'(smp_l_out), 5);
        smp_l_in = -24'sd6;
        tick(1'b0);
        chk_eq("R10 latency b", int'(smp_l_out), -6);

        cur_tag = "R1";
        code_l = 8'd74;
        do_reset();
        smp_l_in = 24'sd1000;
        tick(1'b0);
        chk_eq("R1 half gain", int'(smp_l_out), 500);

        // R3: clamp at +31 dB
        cur_tag = "R3";
        code_l = 8'd0;
        do_reset();
        smp_l_in = 24'sd4194304;
        smp_r_in = -24'sd4194304;
        tick(1'b0);
        chk_eq("R3 clamp high", int'(smp_l_out), 8388607);
        chk_eq("R3 clamp low", int'(smp_r_out), -8388608);

        // R4: three strobes do nothing, the fourth moves one code
        cur_tag = "R4";
        code_l = 8'd62;
        do_reset();
        smp_l_in = 24'sd4194304;
        code_l = 8'd70;
        for (int i = 0; i < 3; i++) begin
            tick(1'b1);
            tick(1'b0);
            tick(1'b0);
        end
        chk_eq("R4 held before dwell", int'(smp_l_out), 4194304);
        tick(1'b1);
        tick(1'b0);
        chk_near("R4 one code after dwell", int'(smp_l_out), predict(4194304, 63));

        // R5: walk lengths
        cur_tag = "R5";
        code_l = 8'd62;
        do_reset();
        code_l = 8'd254;
        ramp_count(254, 900, n);
        chk_eq("R5 0dB to -96dB strobes", n, 768);
        code_l = 8'd0;
        do_reset();
        code_l = 8'd254;
        ramp_count(254, 1200, n);
        chk_eq("R5 +31dB to -96dB strobes", n, 1016);

        // R7: soft mute length
        cur_tag = "R7";
        code_l = 8'd62;
        do_reset();
        mute_req = 1'b1;
        ramp_count(255, 900, n);
        chk_eq("R7 mute strobes", n, 772);

        // R8: release partway and walk back
        cur_tag = "R8";
        mute_req = 1'b0;
        do_reset();
        mute_req = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tick(1'b1);
            tick(1'b0);
        end
        chk_near("R8 partway level", int'(smp_l_out), predict(4194304, 72));
        mute_req = 1'b0;
        ramp_count(62, 200, n);
        chk_eq("R8 return strobes", n, 40);

        // R6: linked and independent control
        cur_tag = "R6";
        smp_r_in = 24'sd3000000;
        link_lr = 1'b1;
        code_l = 8'd50;
        code_r = 8'd100;
        do_reset();
        tick(1'b0);
        chk_near("R6 linked right", int'(smp_r_out), predict(3000000, 50));
        code_r = 8'd10;
        for (int i = 0; i < 8; i++) begin
            tick(1'b1);
            tick(1'b0);
        end
        chk_near("R6 code_r ignored", int'(smp_r_out), predict(3000000, 50));
        link_lr = 1'b0;
        code_r = 8'd100;
        do_reset();
        tick(1'b0);
        chk_near("R6 independent right", int'(smp_r_out), predict(3000000, 100));
        chk_near("R6 independent left", int'(smp_l_out), predict(4194304, 50));

        tick(1'b0);
        report();
    end

endmodule